// File: doc/BRIEF.md
# BT.656 Stream Preamble Filter

This block sits between a parallel digital-video input and a memory-write path. Each pixel-clock cycle that `in_valid` is high it accepts one stream element, 8 or 10 bits wide. It needs no separate sync pins. It recognises the embedded timing reference sequence: an all-ones symbol, two all-zero symbols, then a status word. It checks the protection bits of the status word and tracks the field (F), vertical-blanking (V) and horizontal (H, 1 = end of active video, 0 = start of active video) flags.

Each element is then forwarded or dropped according to one of three capture policies:
- **active picture only**: only picture samples on non-blanking lines pass.
- **vertical blanking only**: every element of the blanking lines passes, control words included.
- **everything**: the whole stream passes.

Forwarded elements leave as a valid/data stream. A start-of-line marker and a start-of-field marker are attached to the element they belong to. Because the all-ones and zero symbols are only known to be a preamble once the status word arrives, every element waits in a three-deep holding line before its pass/drop decision is final.

Two state machines do the work. The detector FSM has the states DET_IDLE, DET_ONES, DET_ZERO1 and DET_ZERO2:
- **DET_IDLE**: goes to DET_ONES on an all-ones symbol.
- **DET_ONES**: goes to DET_ZERO1 on a zero, stays on ones, and goes to DET_IDLE on anything else.
- **DET_ZERO1**: goes to DET_ZERO2 on a zero, to DET_ONES on ones, and to DET_IDLE otherwise.
- **DET_ZERO2**: takes the status word, then goes to DET_ONES on ones and to DET_IDLE otherwise.

The control FSM has the states CTL_OFF, CTL_HUNT and CTL_RUN:
- **CTL_OFF**: goes to CTL_HUNT when enable is high.
- **CTL_HUNT**: goes to CTL_RUN on the first valid reference.
- **CTL_HUNT and CTL_RUN**: both return to CTL_OFF when enable is low.

Top module: `bt656_preamble_filter`

## Requirements
- R1: After reset, and whenever `enable` is low, `out_valid`, `out_sol` and `out_sof` are 0. Elements presented while disabled produce no output, either then or later.
- R2: A reference is an element whose upper 8 bits are 0xFF, then two elements whose upper 8 bits are 0x00, then a status word. In the status word's upper 8 bits, bit 6 is F, bit 5 is V and bit 4 is H. The lower 2 bits of each element are not looked at.
- R3: A status word is valid only if bit 7 is 1, bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. For an invalid word, all four elements are treated as ordinary data and the tracked F/V/H are unchanged.
- R4: With `cap_mode` = 0 (active picture), only elements after a start-of-active-video code on a line with V = 0 are forwarded, up to the next reference. No element of any reference is forwarded.
- R5: With `cap_mode` = 1 (vertical blanking), every element on lines with V = 1 is forwarded, including the four elements of references whose V = 1. Nothing is forwarded on V = 0 lines.
- R6: With `cap_mode` = 2 or 3 (everything), every accepted element is forwarded.
- R7: After `enable` rises, modes 0 and 1 forward nothing until the first valid reference. Tracked F/V/H start as 0/1/1.
- R8: With `wide_mode` = 0 (8-bit elements in bits 9..2), `out_data[1:0]` is 0. With `wide_mode` = 1, all 10 bits pass unchanged.
- R9: `cap_mode` is taken over while disabled. While enabled, a new value applies only to elements after the first valid reference whose F differs from the tracked F. That reference itself uses the old mode.
- R10: `out_sol` marks the element that directly follows a valid reference, if that element is forwarded. In mode 0 this applies after an H = 0 reference; in the other modes, after an H = 1 reference.
- R11: `out_sof` marks the first forwarded non-reference element entering after a valid reference whose F differs from the tracked F.
- R12: Order is preserved. An element appears on the output in the cycle after the edge that accepts the third element following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; low clears all state |
| cap_mode | input | 2 | Capture policy: 0 active picture, 1 vertical blanking, 2/3 everything |
| wide_mode | input | 1 | 1 = 10-bit elements, 0 = 8-bit elements in bits 9..2 |
| in_valid | input | 1 | An element is present on in_data |
| in_data | input | 10 | Stream element |
| out_valid | output | 1 | A forwarded element is on out_data |
| out_data | output | 10 | Forwarded element |
| out_sol | output | 1 | Forwarded element starts a line |
| out_sof | output | 1 | Forwarded element starts a field |

## Verification
The start-of-line and start-of-field markers, and the deferred mode switch, can all land on the same output element. This happens when a field change arrives on a reference that also opens a line. The bench provokes it by changing `cap_mode` mid-field and then sending an end-of-active-video reference with F flipped. It judges the result element by element: the element right after that reference must carry both markers, and it must already follow the new policy, while the line before it still follows the old one.

// File: rtl/bt656_pkg.sv
`timescale 1ns/1ps
package bt656_pkg;

    // Number of symbols ahead of the status word in a timing reference
    localparam int PRE_LEN = 3;

    typedef enum logic [1:0] {
        CAP_ACTIVE  = 2'd0,
        CAP_VBLANK  = 2'd1,
        CAP_ALL     = 2'd2,
        CAP_ALL_ALT = 2'd3
    } cap_mode_t;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_ONES,
        DET_ZERO1,
        DET_ZERO2
    } det_state_t;

    typedef enum logic [1:0] {
        CTL_OFF,
        CTL_HUNT,
        CTL_RUN
    } ctl_state_t;

    // Status word check: marker bit plus the four protection bits
    function automatic logic status_ok(input logic [7:0] w);
        return w[7]
            && (w[3] == (w[5] ^ w[4]))
            && (w[2] == (w[6] ^ w[4]))
            && (w[1] == (w[6] ^ w[5]))
            && (w[0] == (w[6] ^ w[5] ^ w[4]));
    endfunction

endpackage

// File: rtl/bt656_trs_detect.sv
`timescale 1ns/1ps
module bt656_trs_detect
    import bt656_pkg::*;
#(
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [SYNC_W-1:0] sym,
    output logic              trs_hit,
    output logic              word_v,
    output logic              word_h,
    output logic              f_change,
    output logic              cur_v,
    output logic              cur_h
);

    det_state_t st, st_nxt;
    logic accept, is_ones, is_zero, word_ok, word_f;
    logic cur_f;

    always_comb begin
        accept  = enable & in_valid;
        is_ones = &sym;
        is_zero = ~|sym;
        word_ok = status_ok(sym[SYNC_W-1 -: 8]);
        word_f  = sym[SYNC_W-2];
        word_v  = sym[SYNC_W-3];
        word_h  = sym[SYNC_W-4];
        trs_hit  = accept && (st == DET_ZERO2) && word_ok;
        f_change = trs_hit && (word_f != cur_f);
    end

    always_comb begin
        st_nxt = st;
        if (accept) begin
            unique case (st)
                DET_IDLE:  st_nxt = is_ones ? DET_ONES : DET_IDLE;
                DET_ONES:  st_nxt = is_zero ? DET_ZERO1 : (is_ones ? DET_ONES : DET_IDLE);
                DET_ZERO1: st_nxt = is_zero ? DET_ZERO2 : (is_ones ? DET_ONES : DET_IDLE);
                DET_ZERO2: st_nxt = is_ones ? DET_ONES : DET_IDLE;
                default:   st_nxt = DET_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) st <= DET_IDLE;
        else                st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cur_f <= 1'b0;
            cur_v <= 1'b1;
            cur_h <= 1'b1;
        end else if (trs_hit) begin
            cur_f <= word_f;
            cur_v <= word_v;
            cur_h <= word_h;
        end
    end

    // R3: a failed protection check leaves the tracked flags alone
    assert_bad_word_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && st == DET_ZERO2 && !word_ok) |=> ($stable(cur_f) && $stable(cur_v) && $stable(cur_h)));

endmodule

// File: rtl/bt656_ctrl.sv
`timescale 1ns/1ps
module bt656_ctrl
    import bt656_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  cap_mode_t cap_mode,
    input  logic      trs_hit,
    input  logic      f_change,
    output logic      locked,
    output cap_mode_t mode_q,
    output cap_mode_t mode_nxt
);

    ctl_state_t st, st_nxt;
    logic mode_load;

    always_comb begin
        st_nxt = st;
        unique case (st)
            CTL_OFF:  st_nxt = enable ? CTL_HUNT : CTL_OFF;
            CTL_HUNT: st_nxt = !enable ? CTL_OFF : (trs_hit ? CTL_RUN : CTL_HUNT);
            CTL_RUN:  st_nxt = !enable ? CTL_OFF : CTL_RUN;
            default:  st_nxt = CTL_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= CTL_OFF;
        else     st <= st_nxt;
    end

    always_comb begin
        locked    = (st == CTL_RUN);
        mode_load = (st == CTL_OFF) || f_change;
        mode_nxt  = mode_load ? cap_mode : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= CAP_ACTIVE;
        else     mode_q <= mode_nxt;
    end

    // R9: while enabled the policy moves only on a field change
    assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
        (st != CTL_OFF && !f_change) |=> $stable(mode_q));

endmodule

// File: rtl/bt656_gate.sv
`timescale 1ns/1ps
module bt656_gate
    import bt656_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wide_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              trs_hit,
    input  logic              word_v,
    input  logic              word_h,
    input  logic              f_change,
    input  logic              cur_v,
    input  logic              cur_h,
    input  logic              locked,
    input  cap_mode_t         mode_q,
    input  cap_mode_t         mode_nxt,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof
);

    localparam int NARROW_BITS = DATA_W - SYNC_W;
    localparam logic [DATA_W-1:0] NARROW_MASK = {DATA_W{1'b1}} << NARROW_BITS;
    localparam int LAST = PRE_LEN - 1;

    logic [DATA_W-1:0] stg_d   [PRE_LEN];
    logic              stg_vld [PRE_LEN];
    logic              stg_fwd [PRE_LEN];
    logic              stg_sol [PRE_LEN];
    logic              stg_sof [PRE_LEN];

    logic accept, entry_fwd, trs_fwd, new_fwd, new_sof, fire;
    logic sol_pend, sof_pend;

    always_comb begin
        accept = enable & in_valid;
        unique case (mode_q)
            CAP_ACTIVE: begin
                entry_fwd = locked & !cur_v & !cur_h;
                trs_fwd   = 1'b0;
            end
            CAP_VBLANK: begin
                entry_fwd = locked & cur_v;
                trs_fwd   = word_v;
            end
            default: begin
                entry_fwd = 1'b1;
                trs_fwd   = 1'b1;
            end
        endcase
        new_fwd = trs_hit ? trs_fwd : entry_fwd;
        new_sof = sof_pend & new_fwd & !trs_hit;
        fire    = stg_vld[LAST] & (trs_hit ? trs_fwd : stg_fwd[LAST]);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            for (int i = 0; i < PRE_LEN; i++) begin
                stg_d[i]   <= '0;
                stg_vld[i] <= 1'b0;
                stg_fwd[i] <= 1'b0;
                stg_sol[i] <= 1'b0;
                stg_sof[i] <= 1'b0;
            end
            sol_pend  <= 1'b0;
            sof_pend  <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end else if (accept) begin
            out_valid <= fire;
            out_data  <= wide_mode ? stg_d[LAST] : (stg_d[LAST] & NARROW_MASK);
            out_sol   <= fire & stg_sol[LAST];
            out_sof   <= fire & stg_sof[LAST];
            for (int i = LAST; i > 0; i--) begin
                stg_d[i]   <= stg_d[i-1];
                stg_vld[i] <= stg_vld[i-1];
                stg_fwd[i] <= trs_hit ? trs_fwd : stg_fwd[i-1];
                stg_sol[i] <= stg_sol[i-1];
                stg_sof[i] <= stg_sof[i-1];
            end
            stg_d[0]   <= in_data;
            stg_vld[0] <= 1'b1;
            stg_fwd[0] <= new_fwd;
            stg_sol[0] <= sol_pend;
            stg_sof[0] <= new_sof;
            sol_pend   <= trs_hit & ((mode_nxt == CAP_ACTIVE) ? !word_h : word_h);
            if (f_change)                 sof_pend <= 1'b1;
            else if (new_fwd && !trs_hit) sof_pend <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end
    end

    // R1: nothing leaves the block the cycle after it is disabled
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!out_valid && !out_sol && !out_sof));

    // R2: a detected status word always has its three leading symbols held here
    assert_preamble_buffered_R2: assert property (@(posedge clk) disable iff (rst)
        trs_hit |-> (stg_vld[0] && stg_vld[1] && stg_vld[2]
                     && (&stg_d[2][DATA_W-1 -: SYNC_W])
                     && (~|stg_d[1][DATA_W-1 -: SYNC_W])
                     && (~|stg_d[0][DATA_W-1 -: SYNC_W])));

endmodule

// File: rtl/bt656_preamble_filter.sv
`timescale 1ns/1ps
module bt656_preamble_filter
    import bt656_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int SYNC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [1:0]        cap_mode,
    input  logic              wide_mode,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_sof
);

    logic      trs_hit, word_v, word_h, f_change, cur_v, cur_h, locked;
    cap_mode_t mode_q, mode_nxt;

    bt656_trs_detect #(.SYNC_W(SYNC_W)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .in_valid (in_valid),
        .sym      (in_data[DATA_W-1 -: SYNC_W]),
        .trs_hit  (trs_hit),
        .word_v   (word_v),
        .word_h   (word_h),
        .f_change (f_change),
        .cur_v    (cur_v),
        .cur_h    (cur_h)
    );

    bt656_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .cap_mode (cap_mode_t'(cap_mode)),
        .trs_hit  (trs_hit),
        .f_change (f_change),
        .locked   (locked),
        .mode_q   (mode_q),
        .mode_nxt (mode_nxt)
    );

    bt656_gate #(.DATA_W(DATA_W), .SYNC_W(SYNC_W)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .wide_mode (wide_mode),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .trs_hit   (trs_hit),
        .word_v    (word_v),
        .word_h    (word_h),
        .f_change  (f_change),
        .cur_v     (cur_v),
        .cur_h     (cur_h),
        .locked    (locked),
        .mode_q    (mode_q),
        .mode_nxt  (mode_nxt),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sol   (out_sol),
        .out_sof   (out_sof)
    );

endmodule

// File: tb/test_bt656_preamble_filter.sv
`timescale 1ns/1ps
module test_bt656_preamble_filter;

    localparam int MAXE = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic [1:0] cap_mode = 2'd0;
    logic       wide_mode = 1'b1;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       out_valid;
    logic [9:0] out_data;
    logic       out_sol, out_sof;

    bt656_preamble_filter i_bt656_preamble_filter (
        .clk(clk), .rst(rst), .enable(enable), .cap_mode(cap_mode),
        .wide_mode(wide_mode), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [9:0] exp_d [MAXE];
    bit         exp_s [MAXE];
    bit         exp_f [MAXE];
    int         exp_n = 0;
    logic [9:0] got_d [MAXE];
    bit         got_s [MAXE];
    bit         got_f [MAXE];
    int         got_n = 0;

    // bench model of the stream state, built from the requirements
    logic [1:0] m_mode;
    bit m_locked, m_f, m_v, m_h, m_solp, m_sofp;
    int idx = 0;

    always @(negedge clk) begin
        if (out_valid && got_n < MAXE) begin
            got_d[got_n] = out_data;
            got_s[got_n] = out_sol;
            got_f[got_n] = out_sof;
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic send(input logic [9:0] d);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
    endtask

    function automatic bit entry_fwd();
        if (m_mode[1])     return 1'b1;
        if (!m_locked)     return 1'b0;
        if (m_mode == 2'd0) return !m_v && !m_h;
        return m_v;
    endfunction

    function automatic logic [9:0] xy(input bit f, input bit v, input bit h);
        logic [7:0] w;
        w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
        return {w, 2'b00};
    endfunction

    task automatic push_exp(input logic [9:0] d, input bit s, input bit f);
        exp_d[exp_n] = wide_mode ? d : (d & 10'h3FC);
        exp_s[exp_n] = s;
        exp_f[exp_n] = f;
        exp_n++;
    endtask

    task automatic elem(input logic [9:0] d);
        bit fw, so;
        fw = entry_fwd();
        so = m_sofp && fw;
        if (fw) begin
            m_sofp = 1'b0;
            push_exp(d, m_solp, so);
        end
        m_solp = 1'b0;
        send(d);
    endtask

    task automatic delem();
        elem({2'b01, idx[7:0]});
        idx++;
    endtask

    task automatic trs(input bit f, input bit v, input bit h);
        logic [9:0] pd [4];
        bit ts [4];
        bit tf [4];
        bit fw, fin;
        logic [1:0] mode_n;
        pd[0] = 10'h3FF; pd[1] = 10'h003; pd[2] = 10'h003; pd[3] = xy(f, v, h);
        for (int k = 0; k < 3; k++) begin
            fw = entry_fwd();
            ts[k] = m_solp;
            m_solp = 1'b0;
            tf[k] = m_sofp && fw;
            if (fw) m_sofp = 1'b0;
            send(pd[k]);
        end
        ts[3] = 1'b0;
        tf[3] = 1'b0;
        fin = m_mode[1] ? 1'b1 : ((m_mode == 2'd0) ? 1'b0 : v);
        mode_n = (f != m_f) ? cap_mode : m_mode;
        if (fin) for (int k = 0; k < 4; k++) push_exp(pd[k], ts[k], tf[k]);
        if (f != m_f) m_sofp = 1'b1;
        m_mode   = mode_n;
        m_locked = 1'b1;
        m_solp   = (m_mode == 2'd0) ? !h : h;
        m_f = f; m_v = v; m_h = h;
        send(pd[3]);
    endtask

    task automatic line(input bit f, input bit v, input int nh, input int na);
        trs(f, v, 1'b1);
        repeat (nh) delem();
        trs(f, v, 1'b0);
        repeat (na) delem();
    endtask

    task automatic start(input logic [1:0] mode, input bit wide);
        enable = 1'b0;
        in_valid = 1'b0;
        cap_mode = mode;
        wide_mode = wide;
        repeat (2) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        m_mode = mode; m_locked = 0; m_f = 0; m_v = 1; m_h = 1; m_solp = 0; m_sofp = 0;
        got_n = 0; exp_n = 0;
    endtask

    task automatic finish_scn(input string req);
        repeat (3) send({2'b01, 8'hEE});
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_n == exp_n, req, "forwarded count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_d[i] == exp_d[i], req, $sformatf("data of element %0d", i), got_d[i], exp_d[i]);
            chk(got_s[i] == exp_s[i], req, $sformatf("start-of-line of element %0d", i), got_s[i], exp_s[i]);
            chk(got_f[i] == exp_f[i], req, $sformatf("start-of-field of element %0d", i), got_f[i], exp_f[i]);
        end
        enable = 1'b0;
        repeat (2) @(negedge clk);
        got_n = 0; exp_n = 0;
    endtask

    task automatic t_reset();
        chk(!out_valid && !out_sol && !out_sof, "R1", "outputs after reset",
            {out_valid, out_sol, out_sof}, 0);
    endtask

    task automatic t_disabled();
        enable = 1'b0;
        cap_mode = 2'd2;
        got_n = 0;
        send(10'h3FF); send(10'h003); send(10'h003); send(xy(0, 0, 0));
        repeat (6) send({2'b01, 8'h11});
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_n == 0, "R1", "elements while disabled", got_n, 0);
        enable = 1'b1;
        repeat (3) @(negedge clk);
        chk(got_n == 0 && !out_valid, "R1", "nothing released after enable", got_n, 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        got_n = 0;
    endtask

    task automatic t_latency();
        start(2'd2, 1'b1);
        send(10'h155);
        chk(!out_valid, "R12", "output after first element", out_valid, 0);
        send(10'h156);
        send(10'h157);
        chk(!out_valid, "R12", "output after third element", out_valid, 0);
        send(10'h158);
        chk(out_valid && out_data == 10'h155, "R12", "first element after fourth accept",
            {out_valid, out_data}, {1'b1, 10'h155});
        in_valid = 1'b0;
        @(negedge clk);
        chk(!out_valid, "R12", "no output without accept", out_valid, 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        got_n = 0;
    endtask

    task automatic t_entire();
        start(2'd2, 1'b1);
        repeat (3) delem();
        line(0, 1, 3, 3);
        line(0, 0, 2, 5);
        finish_scn("R6 R2");
    endtask

    task automatic t_active();
        start(2'd0, 1'b1);
        repeat (3) delem();
        line(0, 1, 3, 3);
        line(0, 0, 3, 5);
        line(0, 0, 2, 4);
        trs(0, 0, 1);
        repeat (2) delem();
        finish_scn("R4 R7 R10");
    endtask

    task automatic t_vbi();
        start(2'd1, 1'b1);
        repeat (3) delem();
        line(0, 1, 3, 3);
        line(0, 1, 2, 2);
        line(0, 0, 3, 5);
        trs(0, 1, 1);
        repeat (2) delem();
        finish_scn("R5 R7 R10");
    endtask

    task automatic t_prot();
        start(2'd0, 1'b1);
        line(0, 1, 2, 2);
        line(0, 0, 2, 3);
        // end-of-active code with bit 0 of the protection flipped
        elem(10'h3FF); elem(10'h003); elem(10'h003); elem({8'h9C, 2'b00});
        repeat (3) delem();
        trs(0, 0, 1);
        repeat (2) delem();
        finish_scn("R3");
    endtask

    task automatic t_modechg();
        start(2'd0, 1'b1);
        line(0, 1, 2, 2);
        line(0, 0, 2, 4);
        cap_mode = 2'd2;
        line(0, 0, 2, 4);
        trs(1, 1, 1);
        repeat (4) delem();
        trs(1, 1, 0);
        repeat (3) delem();
        finish_scn("R9 R11 R10");
    endtask

    task automatic t_narrow();
        start(2'd2, 1'b0);
        repeat (3) delem();
        line(0, 1, 2, 3);
        line(1, 1, 2, 2);
        finish_scn("R8 R11");
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_latency();
        t_entire();
        t_active();
        t_vbi();
        t_prot();
        t_modechg();
        t_narrow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule